// File: doc/BRIEF.md
# Foraging Behaviour Arbiter

This block decides which basic motion behaviour drives a small mobile agent while it forages. It has two operating states: searching empty-handed, or carrying an item back to the home base. The state moves only on cues sensed from the world: an item has been picked up, the agent has reached home, the item has been handed in, a nearby peer is carrying something, or a collision is about to happen. No internal planning or timer is involved.

The block drives one enable line for each behaviour controller: wander (obstacle avoidance), disperse, home and follow. It also drives a suppress line toward the lower layers and a one-bit carrying flag that a radio link can broadcast to peers. The cue inputs pass through one register stage before any decision is made. The enables and the carrying flag come straight from flip-flops. A cue change therefore reaches the outputs on the second rising clock edge after it is applied.

Top module: `forage_arbiter`

## Requirements
- R1: After reset the block is searching: carrying is 0, wander and disperse are 1, and home, follow and suppress are 0.
- R2: While searching with no collision cue, wander and disperse are 1, and home, follow and suppress are 0.
- R3: While searching, the cue itemHeld=1 with atHome=0 moves the block to carrying. Carrying then sets carrying=1, home=1, disperse=0 and suppress=1 when there is no collision cue.
- R4: While carrying with no collision cue, follow equals peerLoaded. While searching, peerLoaded has no effect and follow stays 0.
- R5: While carrying, the cue atHome=1 together with itemDelivered=1 returns the block to searching (carrying=0). Any other cue combination keeps it carrying.
- R6: While collisionSoon=1, disperse, home and follow are 0 and suppress is 1. The carrying flag still follows the state.
- R7: The wander enable is 1 in every cycle after reset.
- R8: While searching, itemHeld=1 together with atHome=1 keeps the block searching, because delivery takes precedence.
- R9: A change on the cue inputs reaches the outputs on the second rising clock edge after it is applied. The outputs do not move on the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| itemHeld | input | 1 | An item has been picked up |
| atHome | input | 1 | The agent is at the home base |
| itemDelivered | input | 1 | The item has been handed in |
| peerLoaded | input | 1 | A peer carrying an item is nearby |
| collisionSoon | input | 1 | A collision is imminent |
| enWander | output | 1 | Enable for the wander/avoid behaviour |
| enDisperse | output | 1 | Enable for the disperse behaviour |
| enHome | output | 1 | Enable for the homing behaviour |
| enFollow | output | 1 | Enable for the follow behaviour |
| suppressLow | output | 1 | Suppress toward the lower layers |
| carrying | output | 1 | Carrying state for broadcast to peers |

## Verification
The only hidden state is the carrying bit, and the carrying output shows it directly. A wrong state also flips disperse and home in the cycle it appears, so any wrong transition shows on the ports two edges after the cue that caused it. The bench starts from each of the two states and applies every one of the 32 cue combinations. For each combination it checks the outputs after one edge, to confirm they have not moved yet, and after two edges against an arithmetic model.

// File: rtl/forage_pkg.sv
package forage_pkg;
  typedef enum logic {ST_SEARCH = 1'b0, ST_CARRY = 1'b1} forageState_t;

  typedef struct packed {
    logic held;
    logic home;
    logic delivered;
    logic peerLoaded;
    logic collide;
  } cueVec_t;

  typedef struct packed {
    logic carryNext;
    logic followReq;
    logic collide;
  } ctlStrobe_t;
endpackage

// File: rtl/forage_ctl.sv
module forage_ctl
  import forage_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  cueVec_t    cueQ,
  output ctlStrobe_t strobe
);
  forageState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_SEARCH: if (cueQ.held && !cueQ.home) stateNext = ST_CARRY;
      ST_CARRY:  if (cueQ.home && cueQ.delivered) stateNext = ST_SEARCH;
      default:   stateNext = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SEARCH;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.carryNext = (stateNext == ST_CARRY);
    strobe.followReq = cueQ.peerLoaded;
    strobe.collide   = cueQ.collide;
  end

  AST_DELIVER_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CARRY && cueQ.home && cueQ.delivered) |=> state == ST_SEARCH); // R5
  AST_HOME_PRECEDENCE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEARCH && cueQ.held && cueQ.home) |=> state == ST_SEARCH); // R8
endmodule

// File: rtl/forage_path.sv
module forage_path
  import forage_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       itemHeld,
  input  logic       atHome,
  input  logic       itemDelivered,
  input  logic       peerLoaded,
  input  logic       collisionSoon,
  input  ctlStrobe_t strobe,
  output cueVec_t    cueQ,
  output logic       enWander,
  output logic       enDisperse,
  output logic       enHome,
  output logic       enFollow,
  output logic       suppressLow,
  output logic       carrying
);
  always_ff @(posedge clk) begin
    if (!rstN) cueQ <= '0;
    else       cueQ <= '{held: itemHeld, home: atHome, delivered: itemDelivered,
                         peerLoaded: peerLoaded, collide: collisionSoon};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enWander    <= 1'b1;
      enDisperse  <= 1'b1;
      enHome      <= 1'b0;
      enFollow    <= 1'b0;
      suppressLow <= 1'b0;
      carrying    <= 1'b0;
    end else begin
      enWander <= 1'b1;
      carrying <= strobe.carryNext;
      if (strobe.collide) begin
        enDisperse  <= 1'b0;
        enHome      <= 1'b0;
        enFollow    <= 1'b0;
        suppressLow <= 1'b1;
      end else begin
        enDisperse  <= !strobe.carryNext;
        enHome      <= strobe.carryNext;
        enFollow    <= strobe.carryNext && strobe.followReq;
        suppressLow <= strobe.carryNext;
      end
    end
  end

  AST_WANDER_UNDER_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (enDisperse || enHome || enFollow) |-> enWander); // R7
  AST_DISPERSE_HOME_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(enDisperse && enHome)); // R3
  AST_COLLIDE_SOLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.collide |=> (!enDisperse && !enHome && !enFollow && suppressLow)); // R6
  AST_FOLLOW_NEEDS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    enFollow |-> carrying); // R4
endmodule

// File: rtl/forage_arbiter.sv
module forage_arbiter
  import forage_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic itemHeld,
  input  logic atHome,
  input  logic itemDelivered,
  input  logic peerLoaded,
  input  logic collisionSoon,
  output logic enWander,
  output logic enDisperse,
  output logic enHome,
  output logic enFollow,
  output logic suppressLow,
  output logic carrying
);
  cueVec_t    cueQ;
  ctlStrobe_t strobe;

  forage_path uPath (
    .clk(clk), .rstN(rstN),
    .itemHeld(itemHeld), .atHome(atHome), .itemDelivered(itemDelivered),
    .peerLoaded(peerLoaded), .collisionSoon(collisionSoon),
    .strobe(strobe), .cueQ(cueQ),
    .enWander(enWander), .enDisperse(enDisperse), .enHome(enHome),
    .enFollow(enFollow), .suppressLow(suppressLow), .carrying(carrying)
  );

  forage_ctl uCtl (
    .clk(clk), .rstN(rstN), .cueQ(cueQ), .strobe(strobe)
  );
endmodule

// File: tb/forage_arbiter_test.sv
module forage_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic itemHeld = 0, atHome = 0, itemDelivered = 0, peerLoaded = 0, collisionSoon = 0;
  logic enWander, enDisperse, enHome, enFollow, suppressLow, carrying;

  int checks = 0;
  int fails = 0;
  logic modelCarry = 1'b0;
  logic [5:0] lastExp;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  forage_arbiter uut (
    .clk(clk), .rstN(rstN), .itemHeld(itemHeld), .atHome(atHome),
    .itemDelivered(itemDelivered), .peerLoaded(peerLoaded),
    .collisionSoon(collisionSoon), .enWander(enWander), .enDisperse(enDisperse),
    .enHome(enHome), .enFollow(enFollow), .suppressLow(suppressLow),
    .carrying(carrying)
  );

  // order: wander, disperse, home, follow, suppress, carrying
  function automatic logic [5:0] expOut(logic c, logic peer, logic col);
    if (col)    return {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, c};
    else if (c) return {1'b1, 1'b0, 1'b1, peer, 1'b1, 1'b1};
    else        return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  endfunction

  function automatic logic nextCarry(logic c, logic held, logic home, logic deliv);
    if (c) return !(home && deliv);
    else   return held && !home;
  endfunction

  task automatic check(string tag, logic [5:0] exp);
    logic [5:0] act;
    act = {enWander, enDisperse, enHome, enFollow, suppressLow, carrying};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // apply one cue vector; inputs change at a negedge
  task automatic apply(logic [4:0] v, string tag);
    logic nc;
    {itemHeld, atHome, itemDelivered, peerLoaded, collisionSoon} = v;
    @(negedge clk);
    check("R9 no change after first edge", lastExp);
    @(negedge clk);
    nc = nextCarry(modelCarry, v[4], v[3], v[2]);
    modelCarry = nc;
    lastExp = expOut(nc, v[1], v[0]);
    check(tag, lastExp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    lastExp = expOut(1'b0, 1'b0, 1'b0);
    check("R1 reset state", lastExp);
    @(negedge clk);
    check("R2 idle search", lastExp);
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 32; v++) begin
        string tag;
        logic [4:0] cv;
        cv = v[4:0];
        if (s == 1 && !modelCarry) apply(5'b10000, "R3 enter carrying");
        if (s == 0 && modelCarry)  apply(5'b01100, "R5 delivery exit");
        if (cv[0])                              tag = "R6 collision override";
        else if (s == 0 && cv[4] && cv[3])      tag = "R8 delivery precedence";
        else if (s == 0 && cv[4])               tag = "R3 pick up item";
        else if (s == 1 && cv[3] && cv[2])      tag = "R5 return to search";
        else if (cv[1])                         tag = "R4 follow on peer";
        else if (s == 0)                        tag = "R2 search enables";
        else                                    tag = "R5 stay carrying";
        apply(cv, tag);
        if (!enWander) begin
          checks++; fails++;
          $display("FAIL R7 wander actual=%b expected=1", enWander);
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule